// File: doc/BRIEF.md
# Real-Time Clock Periodic and Update Interrupt Flags

This block produces the two timing-driven interrupt sources of a real-time clock. A free-running divider counts ticks of the 32768 Hz time base. A 4-bit rate code picks one of its taps, and each pass of that tap raises a periodic event. Separately, the clock core sends a one-cycle pulse when its once-per-second update has finished, and that pulse raises an update-ended flag.

Both flags sit in an 8-bit status word that software reads. Each flag has an enable bit, and the OR of the enabled, pending flags forms both the summary bit of the status word and the interrupt output. A read strobe on the status word clears every flag at once. The divider runs only while the divider control field from the clock core holds the run code. One other code clears the divider, and every remaining code freezes it.

Top module: `rtc_irq_flags`

## Requirements
- R1: After reset, `status` reads 8'h00 and `irq` is low.
- R2: With `rate_sel` = 4'h0, no periodic event occurs, so status bit 6 is never set.
- R3: For `rate_sel` from 3 to 15, a periodic event occurs once every 2^(rate_sel-1) time-base ticks (3 gives 4 ticks, or 8192 Hz; 6 gives 32 ticks; 15 gives 16384 ticks, or 2 Hz). When the divider starts from zero, the first event falls on the last tick of the first period.
- R4: `rate_sel` 1 and 2 give the same periods as 8 and 9, which are 128 and 256 ticks.
- R5: A pulse on `upd_done` sets status bit 4, the update-ended flag, on the following cycle.
- R6: A periodic event sets status bit 6, the periodic flag, on the following cycle.
- R7: Status bit 7 and `irq` are both equal to (bit 6 AND `pie_en`) OR (bit 4 AND `uie_en`). A flag still sets while its enable is low. Status bits 5 and 3..0 always read 0.
- R8: A cycle with `flag_rd` high clears bits 6 and 4 on the next cycle, so `irq` drops. A flag whose event arrives in the same cycle as the read stays set.
- R9: The divider advances only while `div_ctl` = 3'b010. The value 3'b111 clears the divider to zero. Any other value freezes the divider with its phase kept, and no periodic event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | One-cycle strobe per 32768 Hz time-base period |
| div_ctl | input | 3 | Divider control: 010 run, 111 clear, others hold |
| rate_sel | input | 4 | Periodic rate code |
| upd_done | input | 1 | Pulse when the once-per-second update ends |
| pie_en | input | 1 | Periodic interrupt enable |
| uie_en | input | 1 | Update-ended interrupt enable |
| flag_rd | input | 1 | Status register read strobe; clears flags |
| status | output | 8 | Bit 7 summary, bit 6 periodic flag, bit 4 update-ended flag |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest case to reach is the freeze of the divider partway through a period, because its effect shows only through when the next periodic event arrives. The bench runs the divider for part of a period, freezes it while time-base ticks keep arriving, and checks that no flag appears. It then resumes the divider and checks that the event lands exactly when the remaining ticks are used up. A read strobe that lands in the same cycle as an update pulse is driven directly, to show that the read does not lose the new flag.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam logic [2:0] DIV_RUN = 3'b010;
  localparam logic [2:0] DIV_CLR = 3'b111;

  // codes 1 and 2 reuse the slow taps of codes 8 and 9
  function automatic logic [3:0] fold_rate(input logic [3:0] code);
    case (code)
      4'd1:    return 4'd8;
      4'd2:    return 4'd9;
      default: return code;
    endcase
  endfunction

  // low-bit mask whose all-ones state marks the last tick of a period
  function automatic int unsigned tap_mask(input logic [3:0] code);
    logic [3:0] f;
    f = fold_rate(code);
    if (f == 4'd0) return 0;
    return (32'd1 << (f - 4'd1)) - 32'd1;
  endfunction
endpackage

// File: rtl/rtc_irq_divider.sv
module rtc_irq_divider #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_tick,
  input  logic [2:0]       div_ctl,
  output logic             run,
  output logic [DIV_W-1:0] cnt
);
  import rtc_irq_pkg::*;

  logic clr;
  assign run = (div_ctl == DIV_RUN);
  assign clr = (div_ctl == DIV_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (run && tb_tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_irq_tap.sv
module rtc_irq_tap #(
  parameter int DIV_W = 15
) (
  input  logic             tb_tick,
  input  logic             run,
  input  logic [3:0]       rate_sel,
  input  logic [DIV_W-1:0] cnt,
  output logic             per_evt
);
  import rtc_irq_pkg::*;

  logic [DIV_W-1:0] mask;
  logic             active;

  assign mask    = DIV_W'(tap_mask(rate_sel));
  assign active  = (fold_rate(rate_sel) != 4'd0);
  assign per_evt = run && tb_tick && active && ((cnt & mask) == mask);
endmodule

// File: rtl/rtc_irq_flagbank.sv
module rtc_irq_flagbank #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_evt,
  input  logic             clr_rd,
  output logic [NFLAG-1:0] flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= set_evt[i] | (flags[i] & ~clr_rd);
    end
  end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_tick,
  input  logic [2:0] div_ctl,
  input  logic [3:0] rate_sel,
  input  logic       upd_done,
  input  logic       pie_en,
  input  logic       uie_en,
  input  logic       flag_rd,
  output logic [7:0] status,
  output logic       irq
);
  localparam int NFLAG = 2;
  localparam int PF_I  = 1;
  localparam int UF_I  = 0;

  logic             run;
  logic [DIV_W-1:0] cnt;
  logic             per_evt;
  logic [NFLAG-1:0] flags;
  logic             summary;

  rtc_irq_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .div_ctl(div_ctl),
    .run(run), .cnt(cnt)
  );

  rtc_irq_tap #(.DIV_W(DIV_W)) u_tap (
    .tb_tick(tb_tick), .run(run), .rate_sel(rate_sel), .cnt(cnt),
    .per_evt(per_evt)
  );

  rtc_irq_flagbank #(.NFLAG(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt({per_evt, upd_done}),
    .clr_rd(flag_rd), .flags(flags)
  );

  assign summary = (flags[PF_I] & pie_en) | (flags[UF_I] & uie_en);
  assign status  = {summary, flags[PF_I], 1'b0, flags[UF_I], 4'b0000};
  assign irq     = summary;
endmodule

// File: rtl/rtc_irq_flags_chk.sv
module rtc_irq_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] div_ctl,
  input logic [3:0] rate_sel,
  input logic       upd_done,
  input logic       flag_rd,
  input logic       per_evt,
  input logic [7:0] status,
  input logic       irq
);
  p_rate_zero_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'h0) |-> !per_evt);

  p_hold_no_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctl != 3'b010) |-> !per_evt);

  p_uf_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> status[4]);

  p_pf_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> status[6]);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !per_evt && !upd_done) |=> (!status[6] && !status[4] && !irq));

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[6] && !status[4]) |-> !irq);

  p_unused_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] == 1'b0) && (status[3:0] == 4'h0));
endmodule

bind rtc_irq_flags rtc_irq_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .div_ctl(div_ctl), .rate_sel(rate_sel),
  .upd_done(upd_done), .flag_rd(flag_rd), .per_evt(per_evt),
  .status(status), .irq(irq)
);

// File: tb/rtc_irq_flags_test.sv
module rtc_irq_flags_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_tick = 1'b0;
  logic [2:0] div_ctl = 3'b111;
  logic [3:0] rate_sel = 4'h0;
  logic       upd_done = 1'b0;
  logic       pie_en = 1'b0;
  logic       uie_en = 1'b0;
  logic       flag_rd = 1'b0;
  logic [7:0] status;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_irq_flags uut (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .div_ctl(div_ctl),
    .rate_sel(rate_sel), .upd_done(upd_done), .pie_en(pie_en),
    .uie_en(uie_en), .flag_rd(flag_rd), .status(status), .irq(irq)
  );

  // {rate code, expected period in ticks}
  localparam int NV = 10;
  localparam int VEC [NV][2] = '{
    '{3, 4}, '{4, 8}, '{5, 16}, '{6, 32}, '{12, 2048},
    '{8, 128}, '{1, 128}, '{9, 256}, '{2, 256}, '{15, 16384}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // clear divider and flags, then run with a tick every cycle
  task automatic restart(input logic [3:0] code);
    rate_sel = code; div_ctl = 3'b111; flag_rd = 1'b1; tb_tick = 1'b1;
    step();
    flag_rd = 1'b0; div_ctl = 3'b010;
  endtask

  task automatic measure(input logic [3:0] code, output int n);
    restart(code);
    n = 0;
    while (!status[6] && n < 20000) begin
      step();
      n++;
    end
  endtask

  initial begin
    int n;
    step(); step();
    rst_n = 1'b1;
    check("R1 status", status, 8'h00);
    check("R1 irq", irq, 0);

    // table walk: rate code to period (R3, R4)
    for (int i = 0; i < NV; i++) begin
      measure(4'(VEC[i][0]), n);
      check($sformatf("R3/R4 period code %0d", VEC[i][0]), n, VEC[i][1]);
    end

    // R2: code 0 never raises the periodic flag
    restart(4'h0);
    repeat (1000) step();
    check("R2 no periodic flag", status[6], 0);

    // R6 and R7: periodic flag, enable gating
    measure(4'd3, n);
    check("R6 pf set, pie off", status, 8'h40);
    check("R7 irq off while disabled", irq, 0);
    pie_en = 1'b1; #1;
    check("R7 pf with pie_en", status, 8'hC0);
    check("R7 irq with pie_en", irq, 1);
    div_ctl = 3'b000; flag_rd = 1'b1; step(); flag_rd = 1'b0;
    check("R8 read clears pf", status, 8'h00);
    check("R8 irq drops", irq, 0);
    pie_en = 1'b0;

    // R5 and R7: update-ended flag
    upd_done = 1'b1; step(); upd_done = 1'b0;
    check("R5 uf set, uie off", status, 8'h10);
    check("R7 irq off for uf", irq, 0);
    uie_en = 1'b1; #1;
    check("R7 uf with uie_en", status, 8'h90);
    check("R7 irq with uie_en", irq, 1);

    // R8: read and new update in the same cycle keeps the flag
    upd_done = 1'b1; flag_rd = 1'b1; step(); upd_done = 1'b0; flag_rd = 1'b0;
    check("R8 same-cycle event kept", status, 8'h90);
    flag_rd = 1'b1; step(); flag_rd = 1'b0;
    check("R8 cleared after plain read", status, 8'h00);
    check("R8 irq low after read", irq, 0);
    uie_en = 1'b0;

    // R9: freeze mid-period keeps phase
    restart(4'd3);
    step(); step();                 // two of four ticks used
    div_ctl = 3'b001;
    repeat (20) step();
    check("R9 no event while held", status[6], 0);
    div_ctl = 3'b010;
    step();
    check("R9 not yet after 3 ticks", status[6], 0);
    step();
    check("R9 event on 4th run tick", status[6], 1);

    // R9: clear code restarts the period
    restart(4'd3);
    step(); step(); step();
    div_ctl = 3'b111; step();
    div_ctl = 3'b010;
    step(); step(); step();
    check("R9 clear restarts, 3 ticks", status[6], 0);
    step();
    check("R9 clear restarts, 4 ticks", status[6], 1);

    // R9: ticks absent means divider stays put
    restart(4'd3);
    tb_tick = 1'b0;
    repeat (10) step();
    check("R9 no tick no event", status[6], 0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule